// File: doc/BRIEF.md
# Serial Command Front End for a Four-Channel Digital Potentiometer

This block is the serial slave that sits between a host SPI master (mode 0: data sampled on the rising clock edge, changed on the falling edge) and the register bank of four digital potentiometers. Each pot has one wiper register and four data registers. The block oversamples the serial pins with the fast system clock. It checks an identification byte against its two address straps, then decodes an instruction byte. From that it issues single-cycle requests to the register bank: reads, writes, wiper/data-register transfers, global transfers and step-up/step-down moves. It also returns read data or the bank's write-busy flag on the serial output.

A frame begins when chip select falls and ends when it rises. Transfer commands are two bytes long. Register reads, register writes and the status read are three bytes long. A step command stays open until chip select rises, and each further serial clock moves the selected wiper by one tap. A pause pin can freeze a frame part-way through without losing its progress. The serial output is driven as a data bit plus an enable; the pad turns enable-low into high impedance.

Top module: `qpot_spi_front`

## Requirements
- R1: After reset, `so_en` and `req_valid` are low, and no frame is decoded until `cs_n` has been seen high and then low; a `cs_n` held low through reset release yields no request.
- R2: The first byte of a frame (MSB first) must be `0101` in bits 7:4, `00` in bits 3:2 and equal `dev_addr` in bits 1:0; on any mismatch the rest of the frame produces no request and no output data.
- R3: The second byte holds the opcode in bits 7:4, the data-register index in bits 3:2 and the pot index in bits 1:0; a request carries them on `req_reg` and `req_pot`.
- R4: Opcodes `1010` (write wiper) and `1100` (write data register) take a third byte; after its last bit, one request is issued with op 1 or 3 and `req_wdata` equal to that byte's bits 5:0, bits 7:6 being ignored.
- R5: Opcodes `1001` (read wiper, op 0) and `1011` (read data register, op 2) issue their request after the second byte; `rd_data` is taken one clock after `req_valid`, and during the third byte SO carries `00` followed by the six data bits, MSB first, each bit changing on a falling SCK edge.
- R6: Opcodes `1101` (data register to wiper, op 4) and `1110` (wiper to data register, op 5) issue one request at the end of the second byte; any further clocks in the frame are ignored.
- R7: Opcodes `0001` (global data-to-wiper, op 6) and `1000` (global wiper-to-data, op 7) issue one request only when the pot field is `00`; with any other pot field no request is made.
- R8: The second byte `0101_0001` is a status read: no request is issued and the third byte on SO is seven zeros followed by `wip`, sampled at the end of the second byte.
- R9: Opcode `0010` opens a step frame: every later rising SCK edge issues one request for the selected pot, op 8 (up) when SI is high and op 9 (down) when SI is low.
- R10: Any other opcode, and any second byte `0101_xxxx` other than `0101_0001`, issues no request and leaves the bank unchanged.
- R11: `cs_n` going high at any point ends the frame, clears the bit and byte position and drops `so_en`; the next frame is decoded from its first byte.
- R12: `hold_n` taken low while SCK is low pauses the frame: SCK edges are ignored, no request is issued and `so_en` is low; `hold_n` taken high while SCK is low resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| dev_addr | input | 2 | Address straps compared with the ID byte bits 1:0 |
| wip | input | 1 | Write-busy flag from the register bank |
| rd_data | input | DATA_W | Read data from the bank, valid one clock after a read request |
| so_d | output | 1 | Serial output data bit |
| so_en | output | 1 | Serial output enable; low means high impedance at the pad |
| req_valid | output | 1 | One-clock request strobe to the register bank |
| req_op | output | 4 | Request code 0..9 as listed in R4 to R9 |
| req_pot | output | 2 | Pot index of the request |
| req_reg | output | 2 | Data-register index of the request |
| req_wdata | output | DATA_W | Write data for op 1 and op 3 |

## Verification
The bench goes after the frame-boundary cases. If chip select is already low when reset is released, a design that treats that level as a frame start would write a register. If chip select rises part-way through a byte, a design that keeps its counters would misread the next frame as shifted by four bits. A global transfer with a non-zero pot field, opcodes that are not defined, and the status byte's neighbours are all sent; a loose decoder would change bank contents there, and that shows up in later read-backs. A pause is placed inside both a write byte and a read byte while SCK toggles. A design that counted those toggles would store the wrong value or shift the reply. A transfer frame is followed by extra clocks, and a step frame by a mix of up and down bits, to catch missing or repeated requests.

// File: rtl/qpot_pkg.sv
package qpot_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  // Identification byte: family nibble, two zero bits, strap pair
  localparam logic [3:0] FAMILY_ID = 4'b0101;
  localparam logic [7:0] STATUS_BYTE = 8'b0101_0001;

  // Instruction nibble values
  localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
  localparam logic [3:0] OPC_RD_DREG  = 4'b1011;
  localparam logic [3:0] OPC_WR_DREG  = 4'b1100;
  localparam logic [3:0] OPC_D2W      = 4'b1101;
  localparam logic [3:0] OPC_W2D      = 4'b1110;
  localparam logic [3:0] OPC_ALL_D2W  = 4'b0001;
  localparam logic [3:0] OPC_ALL_W2D  = 4'b1000;
  localparam logic [3:0] OPC_STEP     = 4'b0010;

  typedef enum logic [3:0] {
    REQ_RD_WIPER = 4'd0,
    REQ_WR_WIPER = 4'd1,
    REQ_RD_DREG  = 4'd2,
    REQ_WR_DREG  = 4'd3,
    REQ_D2W      = 4'd4,
    REQ_W2D      = 4'd5,
    REQ_ALL_D2W  = 4'd6,
    REQ_ALL_W2D  = 4'd7,
    REQ_STEP_UP  = 4'd8,
    REQ_STEP_DN  = 4'd9
  } req_op_e;

  typedef enum logic [2:0] {
    PH_ID,
    PH_INSTR,
    PH_DATA,
    PH_STEP,
    PH_IDLE
  } phase_e;

endpackage

// File: rtl/qpot_sync.sv
module qpot_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qpot_cmd_dec.sv
module qpot_cmd_dec
  import qpot_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              bit_rise,
  input  logic              si_bit,
  input  logic [SEL_W-1:0]  strap,
  output logic              req_valid,
  output req_op_e           req_op,
  output logic [SEL_W-1:0]  req_pot,
  output logic [SEL_W-1:0]  req_reg,
  output logic [DATA_W-1:0] req_wdata,
  output logic              ld_stat,
  output logic              ld_bank,
  output logic              rd_phase
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e               phase_q, phase_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-2:0]    sh_q, sh_n;
  logic                 rd_q, rd_n;
  logic                 wr_q, wr_n;
  req_op_e              wop_q, wop_n;
  logic [SEL_W-1:0]     pot_q, pot_n;
  logic [SEL_W-1:0]     reg_q, reg_n;

  logic                 rv_n, lds_n, ldb_n;
  req_op_e              rop_n;
  logic [SEL_W-1:0]     rpot_n, rreg_n;
  logic [DATA_W-1:0]    rwd_n;
  logic [BYTE_W-1:0]    full;

  assign full = {sh_q, si_bit};

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rd_n    = rd_q;
    wr_n    = wr_q;
    wop_n   = wop_q;
    pot_n   = pot_q;
    reg_n   = reg_q;
    rv_n    = 1'b0;
    lds_n   = 1'b0;
    ldb_n   = 1'b0;
    rop_n   = req_op;
    rpot_n  = req_pot;
    rreg_n  = req_reg;
    rwd_n   = req_wdata;

    if (!sel) begin
      phase_n = PH_ID;
      cnt_n   = '0;
    end else if (bit_rise) begin
      cnt_n = cnt_q + CNT_W'(1);
      sh_n  = full[BYTE_W-2:0];
      if (phase_q == PH_STEP) begin
        rv_n   = 1'b1;
        rop_n  = si_bit ? REQ_STEP_UP : REQ_STEP_DN;
        rpot_n = pot_q;
        rreg_n = '0;
      end else if (cnt_q == LAST_BIT) begin
        unique case (phase_q)
          PH_ID: begin
            phase_n = (full == {FAMILY_ID, 2'b00, strap}) ? PH_INSTR : PH_IDLE;
          end
          PH_INSTR: begin
            pot_n   = full[SEL_W-1:0];
            reg_n   = full[2*SEL_W-1:SEL_W];
            rd_n    = 1'b0;
            wr_n    = 1'b0;
            phase_n = PH_IDLE;
            rpot_n  = full[SEL_W-1:0];
            rreg_n  = full[2*SEL_W-1:SEL_W];
            if (full == STATUS_BYTE) begin
              phase_n = PH_DATA;
              rd_n    = 1'b1;
              lds_n   = 1'b1;
            end else begin
              case (full[BYTE_W-1:BYTE_W-4])
                OPC_RD_WIPER, OPC_RD_DREG: begin
                  rv_n    = 1'b1;
                  ldb_n   = 1'b1;
                  rd_n    = 1'b1;
                  phase_n = PH_DATA;
                  rop_n   = (full[BYTE_W-1:BYTE_W-4] == OPC_RD_WIPER) ? REQ_RD_WIPER : REQ_RD_DREG;
                end
                OPC_WR_WIPER, OPC_WR_DREG: begin
                  wr_n    = 1'b1;
                  phase_n = PH_DATA;
                  wop_n   = (full[BYTE_W-1:BYTE_W-4] == OPC_WR_WIPER) ? REQ_WR_WIPER : REQ_WR_DREG;
                end
                OPC_D2W: begin rv_n = 1'b1; rop_n = REQ_D2W; end
                OPC_W2D: begin rv_n = 1'b1; rop_n = REQ_W2D; end
                OPC_ALL_D2W: begin
                  rv_n  = (full[SEL_W-1:0] == '0);
                  rop_n = REQ_ALL_D2W;
                end
                OPC_ALL_W2D: begin
                  rv_n  = (full[SEL_W-1:0] == '0);
                  rop_n = REQ_ALL_W2D;
                end
                OPC_STEP: phase_n = PH_STEP;
                default: phase_n = PH_IDLE;
              endcase
            end
          end
          PH_DATA: begin
            phase_n = PH_IDLE;
            if (wr_q) begin
              rv_n   = 1'b1;
              rop_n  = wop_q;
              rpot_n = pot_q;
              rreg_n = reg_q;
              rwd_n  = full[DATA_W-1:0];
            end
          end
          default: phase_n = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_ID;
      cnt_q     <= '0;
      sh_q      <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      wop_q     <= REQ_WR_WIPER;
      pot_q     <= '0;
      reg_q     <= '0;
      req_valid <= 1'b0;
      req_op    <= REQ_RD_WIPER;
      req_pot   <= '0;
      req_reg   <= '0;
      req_wdata <= '0;
      ld_stat   <= 1'b0;
      ld_bank   <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      rd_q      <= rd_n;
      wr_q      <= wr_n;
      wop_q     <= wop_n;
      pot_q     <= pot_n;
      reg_q     <= reg_n;
      req_valid <= rv_n;
      req_op    <= rop_n;
      req_pot   <= rpot_n;
      req_reg   <= rreg_n;
      req_wdata <= rwd_n;
      ld_stat   <= lds_n;
      ld_bank   <= ldb_n;
    end
  end

  assign rd_phase = (phase_q == PH_DATA) && rd_q;

  // R3: every request is the consequence of a sampled SCK rising edge
  a_r3_req_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(bit_rise));

  // R7: global transfers only leave with pot field 00
  a_r7_global_pot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == REQ_ALL_D2W || req_op == REQ_ALL_W2D)) |-> (req_pot == '0));

endmodule

// File: rtl/qpot_so_shift.sv
module qpot_so_shift
  import qpot_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              bit_fall,
  input  logic              rd_phase,
  input  logic              ld_stat,
  input  logic              ld_bank,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wip,
  output logic              so_d
);

  localparam int PAD = BYTE_W - DATA_W;

  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              pend_q, pend_n;
  logic              so_q, so_n;

  always_comb begin
    sh_n   = sh_q;
    so_n   = so_q;
    pend_n = ld_bank;
    if (ld_stat) sh_n = {{(BYTE_W-1){1'b0}}, wip};
    if (pend_q)  sh_n = {{PAD{1'b0}}, rd_data};
    if (!sel) begin
      so_n = 1'b0;
    end else if (bit_fall) begin
      if (rd_phase) begin
        so_n = sh_q[BYTE_W-1];
        sh_n = {sh_q[BYTE_W-2:0], 1'b0};
      end else begin
        so_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pend_q <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      pend_q <= pend_n;
      so_q   <= so_n;
    end
  end

  assign so_d = so_q;

  // R5: the output bit only moves after a falling SCK edge or on deselect
  a_r5_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_q) |-> ($past(bit_fall) || !$past(sel)));

endmodule

// File: rtl/qpot_spi_front.sv
module qpot_spi_front
  import qpot_pkg::*;
#(
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        dev_addr,
  input  logic              wip,
  input  logic [DATA_W-1:0] rd_data,
  output logic              so_d,
  output logic              so_en,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [1:0]        req_pot,
  output logic [1:0]        req_reg,
  output logic [DATA_W-1:0] req_wdata
);

  localparam int PIN_W = 4;
  // chip select reset value 0: a select already low at reset is not a new frame
  localparam logic [PIN_W-1:0] PIN_RST = 4'b0001;

  logic [1:0] rst_sh_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_ni = rst_sh_q[1];

  logic [PIN_W-1:0] pins_s;
  logic s_cs, s_sck, s_si, s_hold;

  qpot_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     ({cs_n, sck, si, hold_n}),
    .q     (pins_s)
  );
  assign {s_cs, s_sck, s_si, s_hold} = pins_s;

  logic sel_q, sel_n;
  logic csq_q, sckq_q;
  logic paused_q, paused_n;
  logic cs_fall, bit_rise, bit_fall;

  assign cs_fall  = csq_q & ~s_cs;
  assign bit_rise = sel_q & ~paused_q &  s_sck & ~sckq_q;
  assign bit_fall = sel_q & ~paused_q & ~s_sck &  sckq_q;

  always_comb begin
    sel_n    = ~s_cs & (sel_q | cs_fall);
    paused_n = paused_q;
    if (s_cs)        paused_n = 1'b0;
    else if (!s_sck) paused_n = ~s_hold;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      csq_q    <= 1'b0;
      sckq_q   <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sel_q    <= sel_n;
      csq_q    <= s_cs;
      sckq_q   <= s_sck;
      paused_q <= paused_n;
    end
  end

  assign so_en = sel_q & ~paused_q;

  logic    ld_stat, ld_bank, rd_phase;
  req_op_e op_e;

  qpot_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sel       (sel_q),
    .bit_rise  (bit_rise),
    .si_bit    (s_si),
    .strap     (dev_addr),
    .req_valid (req_valid),
    .req_op    (op_e),
    .req_pot   (req_pot),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .ld_stat   (ld_stat),
    .ld_bank   (ld_bank),
    .rd_phase  (rd_phase)
  );
  assign req_op = op_e;

  qpot_so_shift #(.DATA_W(DATA_W)) u_so (
    .clk      (clk),
    .rst_n    (rst_ni),
    .sel      (sel_q),
    .bit_fall (bit_fall),
    .rd_phase (rd_phase),
    .ld_stat  (ld_stat),
    .ld_bank  (ld_bank),
    .rd_data  (rd_data),
    .wip      (wip),
    .so_d     (so_d)
  );

  // R12: a paused frame issues nothing
  a_r12_no_req_paused: assert property (@(posedge clk) disable iff (!rst_ni)
    paused_q |-> !req_valid);

  // R11: a high chip select releases the output on the next clock
  a_r11_cs_high_releases_so: assert property (@(posedge clk) disable iff (!rst_ni)
    s_cs |=> !so_en);

endmodule

// File: tb/qpot_spi_front_tb_top.sv
module qpot_spi_front_tb_top;

  localparam int DW = 6;
  localparam int HP = 10;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wip;
  logic [DW-1:0] rd_data;
  logic so_d, so_en, req_valid;
  logic [3:0] req_op;
  logic [1:0] req_pot, req_reg;
  logic [DW-1:0] req_wdata;

  always #4 clk = ~clk;

  qpot_spi_front #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .dev_addr(STRAP), .wip(wip), .rd_data(rd_data), .so_d(so_d), .so_en(so_en),
    .req_valid(req_valid), .req_op(req_op), .req_pot(req_pot), .req_reg(req_reg),
    .req_wdata(req_wdata)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // behavioural register bank answering the request channel
  int wiper_m [4];
  int dreg_m  [4][4];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        wiper_m[p] <= 0;
        for (int r = 0; r < 4; r++) dreg_m[p][r] <= 0;
      end
      rd_data <= '0;
    end else if (req_valid) begin
      case (req_op)
        4'd0: rd_data <= DW'(wiper_m[req_pot]);
        4'd1: wiper_m[req_pot] <= int'(req_wdata);
        4'd2: rd_data <= DW'(dreg_m[req_pot][req_reg]);
        4'd3: dreg_m[req_pot][req_reg] <= int'(req_wdata);
        4'd4: wiper_m[req_pot] <= dreg_m[req_pot][req_reg];
        4'd5: dreg_m[req_pot][req_reg] <= wiper_m[req_pot];
        4'd6: for (int p = 0; p < 4; p++) wiper_m[p] <= dreg_m[p][req_reg];
        4'd7: for (int p = 0; p < 4; p++) dreg_m[p][req_reg] <= wiper_m[p];
        4'd8: if (wiper_m[req_pot] < 63) wiper_m[req_pot] <= wiper_m[req_pot] + 1;
        4'd9: if (wiper_m[req_pot] > 0)  wiper_m[req_pot] <= wiper_m[req_pot] - 1;
        default: ;
      endcase
    end
  end

  // expected request stream, compared on every clock
  int eq_op[$], eq_pot[$], eq_reg[$], eq_wd[$];
  string eq_tag[$];

  task automatic expect_req(input int op, input int pot, input int rg, input int wd, input string tag);
    eq_op.push_back(op); eq_pot.push_back(pot); eq_reg.push_back(rg);
    eq_wd.push_back(wd); eq_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid && !finished) begin
      n_checks++;
      if (eq_op.size() == 0) begin
        n_errors++;
        $display("FAIL %s unexpected request actual op=%0d pot=%0d expected none", cur_tag, req_op, req_pot);
      end else begin
        int op, pot, rg, wd;
        string tg;
        op = eq_op.pop_front(); pot = eq_pot.pop_front(); rg = eq_reg.pop_front();
        wd = eq_wd.pop_front(); tg = eq_tag.pop_front();
        if (int'(req_op) != op || int'(req_pot) != pot ||
            (rg >= 0 && int'(req_reg) != rg) || (wd >= 0 && int'(req_wdata) != wd)) begin
          n_errors++;
          $display("FAIL %s request actual op=%0d pot=%0d reg=%0d wd=%0h expected op=%0d pot=%0d reg=%0d wd=%0h",
                   tg, req_op, req_pot, req_reg, req_wdata, op, pot, rg, wd);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drained(input string tag);
    repeat (4) @(negedge clk);
    chk(tag, eq_op.size(), 0);
    eq_op.delete(); eq_pot.delete(); eq_reg.delete(); eq_wd.delete(); eq_tag.delete();
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b;
    repeat (HP) @(negedge clk);
    r = so_d;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic cs_start();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HP) @(negedge clk);
  endtask

  function automatic logic [7:0] idb(input logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input bit three, output logic [7:0] r);
    logic [7:0] d;
    cs_start();
    spi_byte(b0, d);
    spi_byte(b1, d);
    r = 8'h00;
    if (three) spi_byte(b2, r);
    cs_end();
  endtask

  task automatic pause_here(input string tag);
    hold_n = 1'b0;
    repeat (HP) @(negedge clk);
    chk(tag, int'(so_en), 0);
    si = 1'b1;
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; repeat (HP) @(negedge clk);
      sck = 1'b0; repeat (HP) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_errors++;
      $display("FAIL watchdog expired in %s", cur_tag);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] d;
    logic b;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wip = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    cur_tag = "R1";
    chk("R1 so_en after reset", int'(so_en), 0);
    chk("R1 req_valid after reset", int'(req_valid), 0);
    // R1 select low through reset: write must be ignored
    spi_byte(idb(STRAP), d); spi_byte(8'hA0, d); spi_byte(8'h11, d);
    chk("R1 so_en without select edge", int'(so_en), 0);
    cs_end();
    drained("R1");

    // R4 write wiper pot 2, upper bits of data byte ignored
    cur_tag = "R4";
    expect_req(1, 2, -1, 'h2A, "R4");
    frame(idb(STRAP), 8'hA2, 8'hEA, 1, r);
    drained("R4");

    // R5 read back wiper pot 2
    cur_tag = "R5";
    expect_req(0, 2, -1, -1, "R5");
    frame(idb(STRAP), 8'h92, 8'h00, 1, r);
    chk("R5 read wiper byte", int'(r), 'h2A);
    drained("R5");

    // R3 write then read data register pot 1 index 3
    cur_tag = "R3";
    expect_req(3, 1, 3, 'h15, "R3");
    frame(idb(STRAP), 8'hCD, 8'h15, 1, r);
    expect_req(2, 1, 3, -1, "R3");
    frame(idb(STRAP), 8'hBD, 8'h00, 1, r);
    chk("R3 R5 read data register", int'(r), 'h15);
    drained("R3");

    // R6 transfer with trailing clocks
    cur_tag = "R6";
    expect_req(1, 1, -1, 'h05, "R6");
    frame(idb(STRAP), 8'hA1, 8'h05, 1, r);
    expect_req(4, 1, 3, -1, "R6");
    frame(idb(STRAP), 8'hDD, 8'hFF, 1, r);
    expect_req(0, 1, -1, -1, "R6");
    frame(idb(STRAP), 8'h91, 8'h00, 1, r);
    chk("R6 wiper after transfer", int'(r), 'h15);
    drained("R6");

    // R7 global transfer with pot field 01 rejected, 00 accepted
    cur_tag = "R7";
    frame(idb(STRAP), 8'h11, 8'h00, 0, r);
    drained("R7 bad pot field");
    expect_req(7, 0, 2, -1, "R7");
    frame(idb(STRAP), 8'h88, 8'h00, 0, r);
    expect_req(2, 2, 2, -1, "R7");
    frame(idb(STRAP), 8'hBA, 8'h00, 1, r);
    chk("R7 global copy landed", int'(r), 'h2A);
    drained("R7");

    // R10 undefined opcodes
    cur_tag = "R10";
    frame(idb(STRAP), 8'h32, 8'h3F, 1, r);
    frame(idb(STRAP), 8'h52, 8'h3F, 1, r);
    frame(idb(STRAP), 8'hF2, 8'h3F, 1, r);
    expect_req(0, 2, -1, -1, "R10");
    frame(idb(STRAP), 8'h92, 8'h00, 1, r);
    chk("R10 wiper untouched", int'(r), 'h2A);
    drained("R10");

    // R8 status reads
    cur_tag = "R8";
    wip = 1'b1;
    frame(idb(STRAP), 8'h51, 8'h00, 1, r);
    chk("R8 status busy", int'(r), 'h01);
    wip = 1'b0;
    frame(idb(STRAP), 8'h51, 8'h00, 1, r);
    chk("R8 status idle", int'(r), 'h00);
    drained("R8");

    // R2 identification mismatches
    cur_tag = "R2";
    frame(8'b0101_0001, 8'hA2, 8'h3F, 1, r);
    chk("R2 no data on wrong address", int'(r), 0);
    frame(8'b0110_0010, 8'hA2, 8'h3F, 1, r);
    frame(8'b0101_0110, 8'hA2, 8'h3F, 1, r);
    drained("R2 mismatches");
    expect_req(0, 2, -1, -1, "R2");
    frame(idb(STRAP), 8'h92, 8'h00, 1, r);
    chk("R2 wiper untouched", int'(r), 'h2A);
    drained("R2");

    // R9 step frame: up, up, up, down
    cur_tag = "R9";
    expect_req(8, 2, -1, -1, "R9");
    expect_req(8, 2, -1, -1, "R9");
    expect_req(8, 2, -1, -1, "R9");
    expect_req(9, 2, -1, -1, "R9");
    cs_start();
    spi_byte(idb(STRAP), d); spi_byte(8'h22, d);
    spi_bit(1'b1, b); spi_bit(1'b1, b); spi_bit(1'b1, b); spi_bit(1'b0, b);
    cs_end();
    expect_req(0, 2, -1, -1, "R9");
    frame(idb(STRAP), 8'h92, 8'h00, 1, r);
    chk("R9 wiper after steps", int'(r), 'h2C);
    drained("R9");

    // R12 pause inside a write byte and inside a read byte
    cur_tag = "R12";
    expect_req(1, 0, -1, 'h33, "R12");
    cs_start();
    spi_byte(idb(STRAP), d); spi_byte(8'hA0, d);
    for (int i = 7; i >= 4; i--) spi_bit(d[0] & 1'b0 | (8'h33 >> i) & 1, b);
    pause_here("R12 so_en low in pause");
    for (int i = 3; i >= 0; i--) spi_bit((8'h33 >> i) & 1, b);
    cs_end();
    expect_req(0, 0, -1, -1, "R12");
    cs_start();
    spi_byte(idb(STRAP), d); spi_byte(8'h90, d);
    for (int i = 7; i >= 5; i--) spi_bit(1'b0, r[i]);
    pause_here("R12 so_en low in read pause");
    for (int i = 4; i >= 0; i--) spi_bit(1'b0, r[i]);
    cs_end();
    chk("R12 read across pause", int'(r), 'h33);
    drained("R12");

    // R11 select rises mid-instruction, next frame still clean
    cur_tag = "R11";
    cs_start();
    spi_byte(idb(STRAP), d);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, b);
    cs_end();
    chk("R11 so_en after deselect", int'(so_en), 0);
    expect_req(1, 3, -1, 'h07, "R11");
    frame(idb(STRAP), 8'hA3, 8'h07, 1, r);
    expect_req(0, 3, -1, -1, "R11");
    frame(idb(STRAP), 8'h93, 8'h00, 1, r);
    chk("R11 read after abort", int'(r), 'h07);
    drained("R11");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule